// File: doc/BRIEF.md
# DC-Balanced Three-Lane Serial Frame Encoder

This block turns a 21-bit parallel word into three serial data lanes plus one clock lane, running at the bit clock. Every frame lasts nine bit clocks. For each lane, a seven-bit slice of the word is sent either as it is or bit-inverted. Two complementary flag bits go in front of it and tell the receiver which was chosen, so the receiver can restore the original data.

Each lane keeps a running digital sum: every transmitted 1 counts +1 and every 0 counts -1. At every frame boundary the sign of that sum decides whether the next slice is inverted, which pulls the sum back toward zero. This lets the link be AC-coupled.

The clock lane sends one pulse per frame. The pulse is alternately four and five bit periods high, so the clock lane also stays balanced. The word is taken when the load strobe is high in the last bit slot of a frame. If the strobe is low at that point, the previous word is encoded again.

Top module: `bal_serial_encoder`

## Requirements
- R1: While reset (active-low, synchronous) is low, all data lane outputs and the clock lane output are 0. Every lane's running sum restarts at zero, so the first frame after reset is never inverted.
- R2: A frame is nine bits long: flag A, then flag B, then the seven data bits from bit 6 down to bit 0. Lane k carries word bits [7k+6:7k].
- R3: The flag pair is A=1, B=0 for an inverted slice and A=0, B=1 for a slice sent as it is. The pair therefore never changes the running sum.
- R4: The slice is inverted in two cases: the boundary sum is positive and the slice has four or more ones, or the boundary sum is negative and the slice has three or fewer ones. A boundary sum of zero never inverts.
- R5: After each frame, a lane's running sum has changed by exactly (2 x ones transmitted - 7).
- R6: On every data lane, the running sum measured bit by bit from reset stays within -10..+10.
- R7: The clock lane sends 111100000 and 111110000 in alternating frames, in that order. The first frame after reset is the four-high one.
- R8: The clock lane's running sum stays within -5..+5.
- R9: The word and load strobe are sampled only in the ninth bit slot of a frame. A load in any other slot has no effect. With load low in the ninth slot, the previously taken word is re-encoded against the current running sums.
- R10: Frames follow each other every nine cycles with no gap. The first frame starts in the cycle after the first clock edge at which reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Word strobe, sampled in the last slot of a frame |
| word | input | 21 | Parallel word, seven bits per lane |
| ser_data | output | 3 | Serial data lanes, one bit per lane |
| ser_clk | output | 1 | Clock lane bit |

## Verification
The bench builds the block with its defaults: three lanes of seven data bits, giving a nine-slot frame. With seven-bit slices, the sum at a frame boundary can reach +/-7, and the three leading bits of the next slice can then push it to exactly +/-10. Directed words steer one lane onto both of these peaks and through a zero boundary sum with a heavy slice. Random words, random skipped loads and strobes in the wrong slot exercise re-encoding and the sampling window. A reset in the middle of a frame confirms that the sums and the clock phase restart.

// File: rtl/bal_enc_pkg.sv
// Shared definitions for the DC-balanced serial frame encoder.
// Assumes: frames carry two flag bits ahead of each data slice.
package bal_enc_pkg;

    // Number of flag bits in front of every data slice
    localparam int unsigned FLAG_BITS = 2;

    // Which pulse width the clock lane sends next
    typedef enum logic {
        PHASE_SHORT = 1'b0,
        PHASE_LONG  = 1'b1
    } clk_phase_e;

endpackage

// File: rtl/bal_frame_timer.sv
// Frame slot counter. Counts 0..FRAME-1 and flags the last slot as the
// frame boundary. After reset it starts on the last slot, so the first
// frame is loaded on the first clock edge after reset.
// Assumes: FRAME >= 2.
module bal_frame_timer #(
    parameter int unsigned FRAME  = 9,
    parameter int unsigned SLOT_W = $clog2(FRAME)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot,
    output logic              boundary
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME - 1);

    assign boundary = (slot == LAST);

    // Advance the slot index and wrap at the end of the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= LAST;
        end else if (boundary) begin
            slot <= '0;
        end else begin
            slot <= slot + SLOT_W'(1);
        end
    end

endmodule

// File: rtl/bal_lane_tx.sv
// One data lane. At each frame boundary it encodes a GROUP-bit slice:
// the slice is inverted when that moves the running sum toward zero,
// and a complementary flag pair is put in front of it. The frame is then
// shifted out MSB first. The running sum register holds the sum at
// frame boundaries.
// Assumes: GROUP is odd, and SUM_W can hold +/-2*GROUP.
module bal_lane_tx #(
    parameter int unsigned GROUP = 7,
    parameter int unsigned SUM_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    boundary,
    input  logic [GROUP-1:0]        group,
    output logic                    ser,
    output logic signed [SUM_W-1:0] sum
);

    localparam int unsigned FRAME = GROUP + bal_enc_pkg::FLAG_BITS;
    localparam int unsigned CNT_W = $clog2(GROUP + 1);
    localparam int unsigned HALF  = GROUP / 2;

    logic [CNT_W-1:0]        ones;
    logic [CNT_W-1:0]        tx_ones;
    logic                    heavy;
    logic                    sum_pos;
    logic                    sum_neg;
    logic                    invert;
    logic [GROUP-1:0]        tx_group;
    logic signed [SUM_W-1:0] delta;
    logic [FRAME-1:0]        frame;
    logic [FRAME-1:0]        shreg;

    // Count the ones in the incoming slice
    always_comb begin
        ones = '0;
        for (int i = 0; i < GROUP; i++) begin
            ones = ones + CNT_W'(group[i]);
        end
    end

    // Choose the polarity from the boundary sum and build the frame
    always_comb begin
        heavy    = (ones > CNT_W'(HALF));
        sum_neg  = sum[SUM_W-1];
        sum_pos  = !sum[SUM_W-1] && (sum != '0);
        invert   = (sum_pos && heavy) || (sum_neg && !heavy);
        tx_group = invert ? ~group : group;
        tx_ones  = invert ? (CNT_W'(GROUP) - ones) : ones;
        delta    = $signed(SUM_W'({tx_ones, 1'b0})) - $signed(SUM_W'(GROUP));
        frame    = {invert, !invert, tx_group};
    end

    // Load a new frame at the boundary, otherwise shift toward the MSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            sum   <= '0;
        end else if (boundary) begin
            shreg <= frame;
            sum   <= sum + delta;
        end else begin
            shreg <= {shreg[FRAME-2:0], 1'b0};
        end
    end

    assign ser = shreg[FRAME-1];

endmodule

// File: rtl/bal_clock_lane.sv
// Clock lane generator. Sends one high pulse per frame. The pulse is
// FRAME/2 and FRAME/2+1 bits wide in alternate frames, starting with the
// shorter one after reset.
// Assumes: FRAME is odd.
module bal_clock_lane #(
    parameter int unsigned FRAME = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    output logic ser
);

    localparam int unsigned      HI_SHORT  = FRAME / 2;
    localparam int unsigned      HI_LONG   = HI_SHORT + 1;
    localparam logic [FRAME-1:0] ALL_ONES  = {FRAME{1'b1}};
    localparam logic [FRAME-1:0] SHORT_PAT = ALL_ONES << (FRAME - HI_SHORT);
    localparam logic [FRAME-1:0] LONG_PAT  = ALL_ONES << (FRAME - HI_LONG);

    bal_enc_pkg::clk_phase_e phase;
    logic [FRAME-1:0]        shreg;

    // Load the next pulse shape at the boundary and swap phase, else shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            phase <= bal_enc_pkg::PHASE_SHORT;
        end else if (boundary) begin
            shreg <= (phase == bal_enc_pkg::PHASE_SHORT) ? SHORT_PAT : LONG_PAT;
            phase <= (phase == bal_enc_pkg::PHASE_SHORT) ?
                     bal_enc_pkg::PHASE_LONG : bal_enc_pkg::PHASE_SHORT;
        end else begin
            shreg <= {shreg[FRAME-2:0], 1'b0};
        end
    end

    assign ser = shreg[FRAME-1];

endmodule

// File: rtl/bal_serial_encoder.sv
// Top level: one slot timer, LANES balanced data lanes and one clock lane.
// The word is taken at a frame boundary when load is high. With load low,
// the held word is encoded again.
// Assumes: GROUP is odd. Outputs are registered, one bit per clock.
module bal_serial_encoder #(
    parameter int unsigned LANES = 3,
    parameter int unsigned GROUP = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [LANES*GROUP-1:0] word,
    output logic [LANES-1:0]       ser_data,
    output logic                   ser_clk
);

    localparam int unsigned FRAME  = GROUP + bal_enc_pkg::FLAG_BITS;
    localparam int unsigned SLOT_W = $clog2(FRAME);
    localparam int unsigned SUM_W  = $clog2(2 * GROUP + 1) + 1;
    localparam int unsigned WORD_W = LANES * GROUP;

    logic [SLOT_W-1:0]           slot;
    logic                        boundary;
    logic [WORD_W-1:0]           held;
    logic [WORD_W-1:0]           src;
    logic [LANES-1:0][SUM_W-1:0] lane_sum;

    bal_frame_timer #(
        .FRAME (FRAME),
        .SLOT_W(SLOT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot    (slot),
        .boundary(boundary)
    );

    // Select the fresh word on a boundary load, otherwise the held one
    always_comb begin
        src = (boundary && load) ? word : held;
    end

    // Keep the last word taken so that it can be re-encoded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (boundary && load) begin
            held <= word;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        bal_lane_tx #(
            .GROUP(GROUP),
            .SUM_W(SUM_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .boundary(boundary),
            .group   (src[k*GROUP +: GROUP]),
            .ser     (ser_data[k]),
            .sum     (lane_sum[k])
        );
    end

    bal_clock_lane #(
        .FRAME(FRAME)
    ) u_clk_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .boundary(boundary),
        .ser     (ser_clk)
    );

endmodule

// File: rtl/bal_serial_encoder_chk.sv
// Property checker for bal_serial_encoder, attached by bind. It keeps its
// own bit-by-bit running sums of the serial outputs and checks them against
// the balance bounds. It also checks the flag pair, the zero-sum polarity,
// the clock pulse edges and the slot range.
module bal_serial_encoder_chk #(
    parameter int unsigned LANES  = 3,
    parameter int unsigned GROUP  = 7,
    parameter int unsigned SLOT_W = 4,
    parameter int unsigned SUM_W  = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [SLOT_W-1:0]           slot,
    input logic                        boundary,
    input logic [LANES-1:0]            ser_data,
    input logic                        ser_clk,
    input logic [LANES-1:0][SUM_W-1:0] lane_sum
);

    localparam int unsigned       FRAME    = GROUP + 2;
    localparam logic [SLOT_W-1:0] LAST     = SLOT_W'(FRAME - 1);
    localparam int unsigned       MW       = SUM_W + 3;
    localparam logic signed [MW-1:0] DATA_HI = MW'(GROUP + GROUP / 2);
    localparam logic signed [MW-1:0] DATA_LO = -DATA_HI;
    localparam logic signed [MW-1:0] CLK_HI  = MW'(FRAME / 2 + 1);
    localparam logic signed [MW-1:0] CLK_LO  = -CLK_HI;
    localparam logic signed [MW-1:0] STEP_UP = MW'(1);
    localparam logic signed [MW-1:0] STEP_DN = -STEP_UP;

    logic                 started;
    logic                 active;
    logic signed [MW-1:0] mon_clk;

    assign active = started || (slot == '0);

    // Mark that the first frame has begun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else if (slot == '0) begin
            started <= 1'b1;
        end
    end

    // Running sum of the clock lane as transmitted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_clk <= '0;
        end else if (active) begin
            mon_clk <= mon_clk + (ser_clk ? STEP_UP : STEP_DN);
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_mon
        logic signed [MW-1:0] mon;

        // Running sum of this data lane as transmitted
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mon <= '0;
            end else if (active) begin
                mon <= mon + (ser_data[k] ? STEP_UP : STEP_DN);
            end
        end

        // R6: the data lane sum stays within its bound
        a_r6_data_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (mon <= DATA_HI) && (mon >= DATA_LO))
            else $error("R6 lane %0d running sum out of bound", k);

        // R4: a zero boundary sum sends the slice true (flag A is 0)
        a_r4_zero_sum_true: assert property (@(posedge clk) disable iff (!rst_n)
            (boundary && (lane_sum[k] == '0)) |=> !ser_data[k])
            else $error("R4 lane %0d inverted at zero sum", k);
    end

    // R3: flag B is always the complement of flag A
    a_r3_flag_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_W'(1)) |-> (ser_data == ~$past(ser_data)))
        else $error("R3 flag pair not complementary");

    // R8: the clock lane sum stays within its bound
    a_r8_clk_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_clk <= CLK_HI) && (mon_clk >= CLK_LO))
        else $error("R8 clock lane sum out of bound");

    // R7: the clock pulse is high in the first slot of every frame
    a_r7_clk_first_high: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == '0) |-> ser_clk)
        else $error("R7 clock lane low in first slot");

    // R7: the clock pulse is low in the last slot of every frame
    a_r7_clk_last_low: assert property (@(posedge clk) disable iff (!rst_n)
        (started && (slot == LAST)) |-> !ser_clk)
        else $error("R7 clock lane high in last slot");

    // R10: the slot index never leaves the frame
    a_r10_slot_legal: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST)
        else $error("R10 slot index out of range");

endmodule

bind bal_serial_encoder bal_serial_encoder_chk #(
    .LANES (LANES),
    .GROUP (GROUP),
    .SLOT_W(SLOT_W),
    .SUM_W (SUM_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot    (slot),
    .boundary(boundary),
    .ser_data(ser_data),
    .ser_clk (ser_clk),
    .lane_sum(lane_sum)
);

// File: tb/bal_serial_encoder_test.sv
// Self-checking bench for bal_serial_encoder: directed corner words plus
// seeded random words, compared bit by bit against a frame model.
module bal_serial_encoder_test;

    localparam int LANES = 3;
    localparam int GROUP = 7;
    localparam int FRAME = GROUP + 2;
    localparam int W     = LANES * GROUP;
    localparam int LIMIT = 200000;

    logic             clk   = 1'b0;
    logic             rst_n = 1'b0;
    logic             load  = 1'b0;
    logic [W-1:0]     word  = '0;
    logic [LANES-1:0] ser_data;
    logic             ser_clk;

    int           checks = 0;
    int           fails  = 0;
    int           mdisp [LANES];
    int           mphase;
    logic [W-1:0] mheld;
    int           run_sum [LANES];
    int           peak [LANES];
    int           clk_run;
    int           clk_peak;

    always #10 clk = ~clk;

    bal_serial_encoder #(
        .LANES(LANES),
        .GROUP(GROUP)
    ) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .word    (word),
        .ser_data(ser_data),
        .ser_clk (ser_clk)
    );

    // Record one check and report it if it failed
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Frame model from R2..R5: returns the nine-bit frame and the next sum
    function automatic logic [FRAME-1:0] encode(input logic [GROUP-1:0] g,
                                                input int d, output int nd);
        int               n;
        logic             inv;
        logic [GROUP-1:0] t;
        n   = $countones(g);
        inv = ((d > 0) && (n >= 4)) || ((d < 0) && (n <= 3));
        t   = inv ? ~g : g;
        nd  = d + 2 * $countones(t) - GROUP;
        return {inv, !inv, t};
    endfunction

    // Clear the model and the observed sums after a reset
    task automatic model_reset();
        for (int k = 0; k < LANES; k++) begin
            mdisp[k]   = 0;
            run_sum[k] = 0;
            peak[k]    = 0;
        end
        mphase   = 0;
        mheld    = '0;
        clk_run  = 0;
        clk_peak = 0;
    endtask

    // Present a word at the boundary slot, then check the nine bits of the frame
    task automatic run_frame(input logic ld, input logic [W-1:0] w,
                             input bit noise, input string tag);
        logic [FRAME-1:0] exp_f [LANES];
        logic [FRAME-1:0] exp_c;
        logic [W-1:0]     src;
        int               nd;
        load  = ld;
        word  = w;
        src   = ld ? w : mheld;
        mheld = src;
        for (int k = 0; k < LANES; k++) begin
            exp_f[k] = encode(src[k*GROUP +: GROUP], mdisp[k], nd);
            mdisp[k] = nd;
        end
        exp_c  = (mphase == 0) ? 9'b111100000 : 9'b111110000;
        mphase = 1 - mphase;
        @(posedge clk);
        for (int s = 0; s < FRAME; s++) begin
            @(negedge clk);
            for (int k = 0; k < LANES; k++) begin
                chk(ser_data[k] == exp_f[k][FRAME-1-s], tag, "data lane bit",
                    int'(ser_data[k]), int'(exp_f[k][FRAME-1-s]));
                run_sum[k] += ser_data[k] ? 1 : -1;
                if (run_sum[k] > peak[k])  peak[k] = run_sum[k];
                if (-run_sum[k] > peak[k]) peak[k] = -run_sum[k];
            end
            chk(ser_clk == exp_c[FRAME-1-s], "R7", "clock lane bit",
                int'(ser_clk), int'(exp_c[FRAME-1-s]));
            clk_run += ser_clk ? 1 : -1;
            if (clk_run > clk_peak)  clk_peak = clk_run;
            if (-clk_run > clk_peak) clk_peak = -clk_run;
            if (s < FRAME - 1) begin
                if (noise) begin
                    load = 1'b1;
                    word = W'($urandom);
                end else begin
                    load = 1'b0;
                end
            end
        end
    endtask

    // Hold reset across two edges and check that the outputs stay quiet
    task automatic apply_reset();
        rst_n = 1'b0;
        load  = 1'b1;
        word  = W'($urandom);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(ser_data == '0, "R1", "data lanes in reset", int'(ser_data), 0);
        chk(ser_clk == 1'b0, "R1", "clock lane in reset", int'(ser_clk), 0);
        model_reset();
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (LIMIT) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired: cycles=%0d expected below %0d", LIMIT, LIMIT);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7211));
        model_reset();
        apply_reset();

        // R1 R4: zero sum at start, heavy slice sent true
        run_frame(1'b1, {3{7'b1111111}}, 1'b0, "R1 R2 R4 R10");
        // R6: sum +7, three leading ones, no inversion, peak +10
        run_frame(1'b1, {3{7'b1110000}}, 1'b0, "R3 R4 R6");
        chk(peak[0] == 10, "R6", "positive peak of lane 0", peak[0], 10);
        run_frame(1'b1, {3{7'b0000000}}, 1'b0, "R4 R5");
        run_frame(1'b1, {3{7'b1111000}}, 1'b0, "R4 R5");
        // R4: boundary sum back at zero, heavy slice sent true
        run_frame(1'b1, {3{7'b1111111}}, 1'b0, "R4 R5");
        run_frame(1'b1, {3{7'b0000000}}, 1'b0, "R4 R5");
        run_frame(1'b1, {3{7'b0000000}}, 1'b0, "R4 R5");
        // R6: sum -7, three leading zeros, trough -10
        run_frame(1'b1, {3{7'b0001111}}, 1'b0, "R3 R6");
        chk(peak[0] == 10, "R6", "negative peak of lane 0", peak[0], 10);
        // R9: load low at the boundary re-encodes the held word
        run_frame(1'b0, W'($urandom), 1'b0, "R9");
        // R9: strobes in the wrong slots are ignored
        run_frame(1'b1, 21'h1A2B3C, 1'b1, "R9 R2");
        run_frame(1'b0, W'($urandom), 1'b1, "R9");

        // Random words, skipped loads and stray strobes
        for (int f = 0; f < 240; f++) begin
            run_frame(($urandom % 4) != 0, W'($urandom), ($urandom % 3) == 0,
                      "R2 R3 R4 R5 R9");
        end
        for (int k = 0; k < LANES; k++) begin
            chk(peak[k] <= 10, "R6", "lane sum peak", peak[k], 10);
        end
        chk(clk_peak <= 5, "R8", "clock lane sum peak", clk_peak, 5);

        // R1: reset in mid-frame restarts the sums and the clock phase
        repeat (4) @(negedge clk);
        apply_reset();
        run_frame(1'b1, {7'b0011111, 7'b1010101, 7'b1111111}, 1'b0, "R1 R7 R10");
        for (int f = 0; f < 20; f++) begin
            run_frame(1'b1, W'($urandom), 1'b0, "R1 R5");
        end
        for (int k = 0; k < LANES; k++) begin
            chk(peak[k] <= 10, "R6", "lane sum peak after reset", peak[k], 10);
        end
        chk(clk_peak <= 5, "R8", "clock lane peak after reset", clk_peak, 5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule